// File: doc/BRIEF.md
# Power-of-Two Sample Averager

This block sits on the output path of a single conversion channel. It takes signed samples as they arrive, each marked by a one-cycle valid strobe. It can forward them unchanged, or it can group them into blocks of 2, 4, 8 or 16 samples and emit one rounded mean per block. A configuration enable selects bypass or averaging, and a 2-bit code selects the block length. Both are plain level inputs that may change at any time.

Whenever the enable or the length code differs from its value in the previous cycle, any partial block is thrown away and counting starts over. A sample that arrives in the same cycle as a change is treated under the new configuration. Averaged results appear on a registered output with their own one-cycle strobe, in the cycle after the sample that completes the block. Data format conversion and serialization are done downstream.

Top module: `pow2_sample_averager`

## Requirements
- R1: After reset, out_valid and out_sample are 0. They stay 0 while in_valid is held low, and the block starts in bypass (averaging off).
- R2: With avg_en = 0, every cycle with in_valid = 1 produces out_valid = 1 in the next cycle, and out_sample equals the input sample unchanged.
- R3: With avg_en = 1, the block length is 2^(depth_code+1): code 0 gives 2 samples, code 1 gives 4, code 2 gives 8 and code 3 gives 16. out_valid pulses exactly once per completed block, in the cycle after the block's last accepted sample.
- R4: The averaged value is (S + 2^depth_code) shifted arithmetically right by depth_code+1, where S is the signed sum of the block. This is round-half-up: for example, a mean of -1.5 gives -1 and a mean of 1.5 gives 2.
- R5: The running sum holds at least 20 bits. A block of full-scale samples (all 32767 or all -32768) at depth 16 yields exactly 32767 or -32768, with no wrap.
- R6: A change of avg_en or depth_code from its value in the previous cycle discards the partial block and clears the sample count. A sample valid in the change cycle is the first sample of a new block.
- R7: out_valid is never 1 unless in_valid was 1 in the previous cycle. Cycles with in_valid = 0 inside a block neither add samples nor restart the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 16 | Signed input sample |
| avg_en | input | 1 | 1 = averaging, 0 = bypass |
| depth_code | input | 2 | Block length code, length = 2^(code+1) |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 16 | Signed output sample (mean or bypassed value) |

## Verification
The assertions assume that avg_en and depth_code are sampled on the same edge as in_valid. They also assume that a configuration change may coincide with a valid sample, so the bypass and clearing properties are written to hold in that cycle too. The random stimulus drives every input only on the falling clock edge. It changes the configuration at random and sometimes while a sample is present, and it includes long runs of idle cycles inside blocks. Directed sequences add full-scale blocks, half-way rounding cases, and changes of code in the middle of a block.

// File: rtl/pow2_sample_averager.sv
module pow2_sample_averager #(
  parameter int SAMPLE_W = 16,
  parameter int CODE_W   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  input  logic                       avg_en,
  input  logic [CODE_W-1:0]          depth_code,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_sample
);

  localparam int MAX_SHIFT = 1 << CODE_W;
  localparam int ACC_W     = SAMPLE_W + MAX_SHIFT;
  localparam int CNT_W     = MAX_SHIFT;

  logic                    en_q;
  logic [CODE_W-1:0]       code_q;
  logic signed [ACC_W-1:0] acc;
  logic [CNT_W-1:0]        cnt;

  logic                    cfg_chg;
  logic [CODE_W:0]         shamt;
  logic [CNT_W-1:0]        last_idx;
  logic signed [ACC_W-1:0] acc_base;
  logic [CNT_W-1:0]        cnt_base;
  logic signed [ACC_W-1:0] sum_next;
  logic signed [ACC_W:0]   rnd;
  logic signed [SAMPLE_W-1:0] mean;
  logic                    block_done;

  assign cfg_chg    = (avg_en != en_q) || (depth_code != code_q);
  assign shamt      = {1'b0, depth_code} + (CODE_W+1)'(1);
  assign last_idx   = ~({CNT_W{1'b1}} << shamt);
  assign acc_base   = cfg_chg ? '0 : acc;
  assign cnt_base   = cfg_chg ? '0 : cnt;
  assign sum_next   = acc_base + {{MAX_SHIFT{in_sample[SAMPLE_W-1]}}, in_sample};
  assign rnd        = {sum_next[ACC_W-1], sum_next} + ((ACC_W+1)'(1) << depth_code);
  assign mean       = SAMPLE_W'(rnd >>> shamt);
  assign block_done = in_valid && avg_en && (cnt_base == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      code_q     <= '0;
      acc        <= '0;
      cnt        <= '0;
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      en_q      <= avg_en;
      code_q    <= depth_code;
      out_valid <= in_valid && (!avg_en || block_done);
      if (in_valid && !avg_en)
        out_sample <= in_sample;
      else if (block_done)
        out_sample <= mean;
      if (!avg_en || block_done) begin
        acc <= '0;
        cnt <= '0;
      end else if (in_valid) begin
        acc <= sum_next;
        cnt <= cnt_base + CNT_W'(1);
      end else begin
        acc <= acc_base;
        cnt <= cnt_base;
      end
    end
  end

  a_r2_bypass_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!avg_en && in_valid) |=> (out_valid && out_sample == $past(in_sample)));

  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < (1 << (int'(code_q) + 1)));

  a_r6_cfg_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_chg && !in_valid) |=> (cnt == '0 && acc == '0));

  a_r2_bypass_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (cnt == '0 && acc == '0));

endmodule

// File: tb/test_pow2_sample_averager.sv
module test_pow2_sample_averager;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_sample = '0;
  logic avg_en = 1'b0;
  logic [1:0] depth_code = '0;
  logic out_valid;
  logic signed [15:0] out_sample;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  bit m_en = 1'b0;
  logic [1:0] m_code = '0;
  int m_acc = 0;
  int m_cnt = 0;
  bit exp_v = 1'b0;
  logic signed [15:0] exp_s = '0;
  string exp_tag = "R1";
  string focus = "";

  pow2_sample_averager i_pow2_sample_averager (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .avg_en(avg_en), .depth_code(depth_code),
    .out_valid(out_valid), .out_sample(out_sample));

  always #2 clk = ~clk;

  function automatic logic signed [15:0] rounded_mean(int sum, logic [1:0] code);
    int r;
    r = (sum + (1 << code)) >>> (int'(code) + 1);
    return 16'(r);
  endfunction

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cycle(bit v, logic signed [15:0] s, bit en, logic [1:0] code);
    string t;
    t = (focus != "") ? focus : exp_tag;
    check({t, " out_valid"}, int'(out_valid), int'(exp_v));
    if (exp_v) check({t, " out_sample"}, int'(out_sample), int'(exp_s));
    in_valid = v; in_sample = s; avg_en = en; depth_code = code;
    if (en != m_en || code != m_code) begin
      m_acc = 0; m_cnt = 0;
    end
    exp_v = 1'b0;
    exp_tag = "R7";
    if (v && !en) begin
      exp_v = 1'b1; exp_s = s; exp_tag = "R2";
    end else if (v) begin
      m_acc += int'(s);
      if (m_cnt == (1 << (int'(code) + 1)) - 1) begin
        exp_v = 1'b1; exp_s = rounded_mean(m_acc, code); exp_tag = "R4";
        m_acc = 0; m_cnt = 0;
      end else m_cnt++;
    end
    if (!en) begin m_acc = 0; m_cnt = 0; end
    m_en = en; m_code = code;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 out_sample", int'(out_sample), 0);
    repeat (3) cycle(1'b0, 16'sd0, 1'b0, 2'd0);

    // R2 bypass
    focus = "R2";
    cycle(1'b1, 16'sd123, 1'b0, 2'd3);
    cycle(1'b1, -16'sd7, 1'b0, 2'd3);
    cycle(1'b0, 16'sd0, 1'b0, 2'd3);
    cycle(1'b1, 16'sh8000, 1'b0, 2'd3);
    cycle(1'b0, 16'sd0, 1'b0, 2'd3);

    // R4 rounding at half: (1+2)/2 -> 2, (-1-2)/2 -> -1
    focus = "R4";
    cycle(1'b1, 16'sd1, 1'b1, 2'd0);
    cycle(1'b1, 16'sd2, 1'b1, 2'd0);
    cycle(1'b1, -16'sd1, 1'b1, 2'd0);
    cycle(1'b1, -16'sd2, 1'b1, 2'd0);
    cycle(1'b0, 16'sd0, 1'b1, 2'd0);
    check("R4 half-up negative", int'(out_sample), -1);

    // R3 each depth with gaps, R7 gaps keep the block
    focus = "R3";
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < (2 << c); k++) begin
        cycle(1'b1, 16'(k * 100 - 300), 1'b1, 2'(c));
        cycle(1'b0, 16'sd0, 1'b1, 2'(c));
      end
    end

    // R5 full scale at depth 16
    focus = "R5";
    for (int k = 0; k < 16; k++) cycle(1'b1, 16'sh7fff, 1'b1, 2'd3);
    cycle(1'b0, 16'sd0, 1'b1, 2'd3);
    check("R5 positive full scale", int'(out_sample), 32767);
    for (int k = 0; k < 16; k++) cycle(1'b1, 16'sh8000, 1'b1, 2'd3);
    cycle(1'b0, 16'sd0, 1'b1, 2'd3);
    check("R5 negative full scale", int'(out_sample), -32768);

    // R6 code change mid block, sample in change cycle starts new block
    focus = "R6";
    cycle(1'b1, 16'sd1000, 1'b1, 2'd1);
    cycle(1'b1, 16'sd1000, 1'b1, 2'd1);
    cycle(1'b1, 16'sd10, 1'b1, 2'd0);
    cycle(1'b1, 16'sd20, 1'b1, 2'd0);
    cycle(1'b0, 16'sd0, 1'b1, 2'd0);
    check("R6 fresh block mean", int'(out_sample), 15);
    cycle(1'b1, 16'sd500, 1'b1, 2'd0);
    cycle(1'b0, 16'sd0, 1'b0, 2'd0);
    cycle(1'b0, 16'sd0, 1'b1, 2'd0);
    cycle(1'b1, 16'sd4, 1'b1, 2'd0);
    cycle(1'b1, 16'sd6, 1'b1, 2'd0);
    cycle(1'b0, 16'sd0, 1'b1, 2'd0);
    check("R6 toggle discards partial", int'(out_sample), 5);

    // random mix
    focus = "";
    begin
      bit en; logic [1:0] code;
      en = 1'b1; code = 2'd2;
      for (int i = 0; i < 4000; i++) begin
        bit v; logic signed [15:0] s;
        if ($urandom % 48 == 0) en = 1'($urandom);
        if ($urandom % 40 == 0) code = 2'($urandom);
        v = ($urandom % 4) != 0;
        case ($urandom % 8)
          0: s = 16'sh7fff;
          1: s = 16'sh8000;
          default: s = 16'($urandom);
        endcase
        cycle(v, s, en, code);
      end
    end
    cycle(1'b0, 16'sd0, 1'b1, 2'd0);
    cycle(1'b0, 16'sd0, 1'b1, 2'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule